// File: doc/BRIEF.md
# Key-Press Wakeup Detector

This block guards the key-matrix return lines of a handheld infrared transmitter while the chip sits in its low-power hold state. A pressed key pulls one of the return lines high. When such a line is eligible as a wake source, the block raises a wakeup request for the clock and power controller. Eight lines are watched: four from the G group, three from the E group and one from the D group.

The rule that makes a line eligible depends on the line. The input-only E line can always wake the chip. A G line can wake the chip whenever its output latch holds zero, because that is the only state in which the bidirectional pin acts as an input. The two bidirectional E lines and the D line also need their own pull-down enable bit to be set. Each pin level passes through a two-stage synchronizer before it is masked. The request is sticky, and a status word records which lines caused it.

Top module: `keywake_monitor`

## Requirements
- R1: The line index is fixed as follows: bits 0 to 3 are G0 to G3, bit 4 is E0, bit 5 is E1, bit 6 is E2 and bit 7 is D7. On `pden`, bit 0 qualifies E0, bit 1 qualifies E1 and bit 2 qualifies D7.
- R2: A G line is eligible exactly when its `out_latch` bit is 0. A high level on a G line whose latch bit is 1 never raises `wake_req`.
- R3: E0, E1 and D7 are eligible only when their `pden` bit is 1 and their `out_latch` bit is 0. If either condition fails, a high level on that line has no effect.
- R4: E2 (bit 6) is always eligible. Its `out_latch` bit and every `pden` bit have no effect on it.
- R5: Detection follows the level, not an edge. A high level on an eligible line raises `wake_req` on the third rising edge after the level is applied, because two synchronizer stages come before the request register. A line that is already high when it becomes eligible also raises the request.
- R6: `wake_req` stays high until `clr_strobe` is sampled high in a cycle where every eligible synchronized line is low. A clear that arrives while an eligible line is still high is ignored.
- R7: `wake_src` takes the set of eligible high lines in the cycle that `wake_req` is set. It holds that value while the request stays pending, and it is zero whenever `wake_req` is low.
- R8: A synchronous active-high `rst` clears `wake_req`, `wake_src`, the synchronizers and the eligibility mask. The mask reloads from `out_latch` and `pden` one clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 8 | Pin levels of the eight return lines (R1 order) |
| out_latch | input | 8 | Output latch value for each line |
| pden | input | 3 | Pull-down enable bits for E0, E1 and D7 |
| clr_strobe | input | 1 | Request to clear the pending wakeup |
| wake_req | output | 1 | Sticky wakeup request |
| wake_src | output | 8 | Lines that caused the pending wakeup |

## Verification
The assertions assume that reset is held from time zero through at least the first clock edge. They also assume that `clr_strobe` is a plain level sampled on each edge, with no relation to the pin inputs. The bench asserts reset from the start and changes pins, configuration and the clear strobe only on falling edges. It lowers the lines and waits for them to pass through the synchronizers before it expects a clear to succeed. Each scenario starts from a fresh reset, so the sticky state never carries over between tests.

// File: rtl/kwm_pkg.sv
package kwm_pkg;

    localparam int NLINES   = 8;
    localparam int NPD      = 3;
    localparam int NUM_G    = 4;
    localparam int LN_E0    = 4;
    localparam int LN_E1    = 5;
    localparam int LN_E2    = 6;
    localparam int LN_D7    = 7;

    typedef logic [NLINES-1:0] line_vec_t;

    // How a line earns eligibility as a wake source
    typedef enum logic [1:0] {
        QUAL_LATCH    = 2'd0,   // latch must be zero
        QUAL_PULLDOWN = 2'd1,   // pull-down bit set and latch zero
        QUAL_ALWAYS   = 2'd2    // input-only line
    } qual_e;

    typedef struct packed {
        logic      pending;
        line_vec_t cause;
    } wake_state_t;

    function automatic qual_e line_qual(input int idx);
        if (idx == LN_E2)
            return QUAL_ALWAYS;
        else if (idx == LN_E0 || idx == LN_E1 || idx == LN_D7)
            return QUAL_PULLDOWN;
        else
            return QUAL_LATCH;
    endfunction

    // Which pull-down control bit qualifies a given line
    function automatic int pd_bit(input int idx);
        if (idx == LN_E0)      return 0;
        else if (idx == LN_E1) return 1;
        else                   return 2;
    endfunction

endpackage

// File: rtl/kwm_sync.sv
module kwm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/kwm_qualify.sv
module kwm_qualify
    import kwm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  line_vec_t      out_latch,
    input  logic [NPD-1:0] pden,
    output line_vec_t      mask_q
);
    line_vec_t en_d;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        localparam qual_e Q = line_qual(i);
        if (Q == QUAL_ALWAYS) begin : g_always
            // latch value carries no meaning on the input-only line
            assign en_d[i] = out_latch[i] | 1'b1;
        end else if (Q == QUAL_PULLDOWN) begin : g_pd
            assign en_d[i] = pden[pd_bit(i)] & ~out_latch[i];
        end else begin : g_lat
            assign en_d[i] = ~out_latch[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= en_d;
    end
endmodule

// File: rtl/kwm_sticky.sv
module kwm_sticky
    import kwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  line_vec_t   active,
    input  logic        clr,
    output wake_state_t st
);
    wake_state_t nxt;

    always_comb begin
        nxt = st;
        if (!st.pending && (|active)) begin
            nxt.pending = 1'b1;
            nxt.cause   = active;
        end else if (st.pending && clr && !(|active)) begin
            nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end
endmodule

// File: rtl/keywake_monitor.sv
module keywake_monitor
    import kwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     pin_lvl,
    input  logic [7:0]     out_latch,
    input  logic [2:0]     pden,
    input  logic           clr_strobe,
    output logic           wake_req,
    output logic [7:0]     wake_src
);
    line_vec_t   pin_s;
    line_vec_t   mask_q;
    line_vec_t   active_w;
    wake_state_t st;

    kwm_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_lvl),
        .q   (pin_s)
    );

    kwm_qualify u_qual (
        .clk       (clk),
        .rst       (rst),
        .out_latch (out_latch),
        .pden      (pden),
        .mask_q    (mask_q)
    );

    assign active_w = pin_s & mask_q;

    kwm_sticky u_sticky (
        .clk    (clk),
        .rst    (rst),
        .active (active_w),
        .clr    (clr_strobe),
        .st     (st)
    );

    assign wake_req = st.pending;
    assign wake_src = st.cause;
endmodule

// File: rtl/kwm_checker.sv
module kwm_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] mask_q,
    input logic [7:0] active_w,
    input logic [2:0] pden,
    input logic       clr_strobe,
    input logic       wake_req,
    input logic [7:0] wake_src
);
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        wake_req && !clr_strobe |=> wake_req);

    p_clear_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        wake_req && (active_w != 8'h00) |=> wake_req);

    p_clear_done_r6: assert property (@(posedge clk) disable iff (rst)
        wake_req && clr_strobe && (active_w == 8'h00) |=> !wake_req);

    p_cause_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> wake_src != 8'h00);

    p_cause_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !wake_req |-> wake_src == 8'h00);

    p_cause_held_r7: assert property (@(posedge clk) disable iff (rst)
        wake_req && $past(wake_req) |-> $stable(wake_src));

    p_e2_always_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> mask_q[6]);

    p_d7_pulldown_r3: assert property (@(posedge clk) disable iff (rst)
        mask_q[7] |-> $past(pden[2]));

    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> !wake_req && wake_src == 8'h00 && mask_q == 8'h00);
endmodule

bind keywake_monitor kwm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mask_q     (mask_q),
    .active_w   (active_w),
    .pden       (pden),
    .clr_strobe (clr_strobe),
    .wake_req   (wake_req),
    .wake_src   (wake_src)
);

// File: tb/test_keywake_monitor.sv
module test_keywake_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_lvl = '0;
    logic [7:0] out_latch = 8'hFF;
    logic [2:0] pden = '0;
    logic       clr_strobe = 1'b0;
    logic       wake_req;
    logic [7:0] wake_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keywake_monitor i_keywake_monitor (
        .clk        (clk),
        .rst        (rst),
        .pin_lvl    (pin_lvl),
        .out_latch  (out_latch),
        .pden       (pden),
        .clr_strobe (clr_strobe),
        .wake_req   (wake_req),
        .wake_src   (wake_src)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input bit exp_req, input logic [7:0] exp_src);
        chk(wake_req == exp_req, req, int'(wake_req), int'(exp_req));
        chk(wake_src == exp_src, req, int'(wake_src), int'(exp_src));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pin_lvl = '0; out_latch = 8'hFF; pden = '0; clr_strobe = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic pulse_clear();
        clr_strobe = 1'b1;
        tick(1);
        clr_strobe = 1'b0;
    endtask

    // R8: reset holds everything idle even with an eligible line high
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; out_latch = 8'h00; pden = 3'b111; pin_lvl = 8'h01;
        tick(4);
        chk_state("R8 reset", 1'b0, 8'h00);
        pin_lvl = 8'h00;
        rst = 1'b0;
        tick(4);
        chk_state("R8 after release", 1'b0, 8'h00);
    endtask

    // R2 and R5: G lines gated by latch, level already high wakes once eligible
    task automatic t_g_lines();
        do_reset();
        out_latch = 8'hFF; pin_lvl = 8'h0F;
        tick(5);
        chk_state("R2 latch set blocks G", 1'b0, 8'h00);
        out_latch = 8'h00;
        tick(3);
        chk_state("R5 held level wakes", 1'b1, 8'h0F);
    endtask

    // R3: pull-down bit and latch both required
    task automatic t_qualified();
        do_reset();
        out_latch = 8'h00; pden = 3'b000; pin_lvl = 8'hB0;
        tick(5);
        chk_state("R3 no pulldown ignored", 1'b0, 8'h00);
        pden = 3'b101; out_latch = 8'h80;
        tick(3);
        chk_state("R3 only E0 qualified", 1'b1, 8'h10);
    endtask

    // R4: E2 wakes regardless of latch and pull-down bits
    task automatic t_e2();
        do_reset();
        out_latch = 8'hFF; pden = 3'b000; pin_lvl = 8'h40;
        tick(3);
        chk_state("R4 E2 always", 1'b1, 8'h40);
    endtask

    // R6: sticky, clear blocked while high, clear works once low
    task automatic t_sticky();
        do_reset();
        out_latch = 8'hFF; pin_lvl = 8'h40;
        tick(3);
        pin_lvl = 8'h00;
        tick(4);
        chk_state("R6 sticky after release", 1'b1, 8'h40);
        pin_lvl = 8'h40;
        tick(3);
        pulse_clear();
        chk_state("R6 clear ignored while high", 1'b1, 8'h40);
        pin_lvl = 8'h00;
        tick(3);
        pulse_clear();
        chk_state("R6 clear when low", 1'b0, 8'h00);
    endtask

    // R7: cause captured at set, later lines not added
    task automatic t_capture();
        do_reset();
        out_latch = 8'h00; pden = 3'b111; pin_lvl = 8'h01;
        tick(3);
        chk_state("R7 first cause", 1'b1, 8'h01);
        pin_lvl = 8'h03;
        tick(4);
        chk_state("R7 cause held", 1'b1, 8'h01);
    endtask

    // R5 and R1: latency of three edges on the D7 line
    task automatic t_latency();
        do_reset();
        out_latch = 8'h00; pden = 3'b100;
        tick(2);
        pin_lvl = 8'h80;
        tick(2);
        chk_state("R5 not yet at edge two", 1'b0, 8'h00);
        tick(1);
        chk_state("R1 D7 at bit 7 on edge three", 1'b1, 8'h80);
    endtask

    initial begin
        t_reset();
        t_g_lines();
        t_qualified();
        t_e2();
        t_sticky();
        t_capture();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule